// File: doc/BRIEF.md
# Two-Level Priority Arbiter for DMA Channels

This block decides which of 32 DMA channels the transfer engine serves next. Every channel owns one byte-wide priority register holding three things: a programmable 4-bit channel rank, a 2-bit group rank that hardware fixes from the channel index, and a flag that allows the channel's running transfer to be interrupted. When fixed-priority mode is on, a pending request is ranked first by group, then by channel rank, and then by the lower channel index. When the mode is off, the priority fields have no effect and the lowest-numbered pending channel wins.

The engine reports whether it is busy and which channel it is serving. An idle engine with work pending receives a one-cycle grant pulse together with a registered channel number. A busy engine receives a grant only as part of a preemption. `preempt_req` rises when the active channel allows suspension and some pending channel ranks strictly above it. In that case the grant names the channel that interrupts.

Software reaches the registers through a write strobe, an address, write data and combinational read data. Channel n sits at address `REG_BASE + n`.

Top module: `dma_prio_arbiter`

## Requirements
- R1: After reset, the register of channel n reads back as the byte {allow_preempt, 0, group[1:0], rank[3:0]}, with allow_preempt in bit 7, group in bits 5:4 and rank in bits 3:0. The reset values are allow_preempt = 0, rank = n mod 16 and group = n div 16. Channel 31 therefore reads 0x1F.
- R2: Channel n's register is written and read at address REG_BASE + n, with REG_BASE = 0x40 by default. A write to an address outside REG_BASE .. REG_BASE+31 changes no register, and a read from such an address returns 0.
- R3: A write updates only bit 7 and bits 3:0. Bits 5:4 (group) keep their reset value. Bit 6 always reads 0.
- R4: With fixed_prio_en = 1, the winner among pending requests has the highest group. Ties go to the highest rank, and any remaining tie goes to the lowest channel index.
- R5: With fixed_prio_en = 0, the lowest-indexed pending channel wins and preempt_req stays 0.
- R6: grant is a registered one-cycle pulse. It rises one clock after a cycle in which a request is pending, the engine is idle (or R9 applies), and grant was low. grant is never high in two consecutive cycles, and it is 0 after reset.
- R7: grant_ch takes the winning channel on the same edge that raises grant. Otherwise it holds its value, and it is 0 after reset.
- R8: preempt_req is combinational. It is 1 exactly when engine_busy = 1, fixed_prio_en = 1, the active channel's allow_preempt = 1, and the winning pending channel's {group, rank} is strictly greater than the active channel's.
- R9: While engine_busy = 1, a grant is issued only for a preemption (R8) and names the preempting channel. Equal rank never preempts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| fixed_prio_en | input | 1 | Enables group/rank arbitration |
| req | input | 32 | Pending service requests, one bit per channel |
| engine_busy | input | 1 | Transfer engine is serving a channel |
| active_ch | input | 5 | Channel currently served |
| grant | output | 1 | One-cycle grant pulse |
| grant_ch | output | 5 | Granted channel, held until the next grant |
| preempt_req | output | 1 | Active transfer should be suspended |

## Verification
The assertions assume that active_ch names a real channel whenever engine_busy is high, and that the engine goes busy only on a channel it was just granted. The bench drives a simple engine that does exactly this. It latches grant_ch as the active channel on every grant, including preemptive ones, and drops the request of a channel when its transfer finishes. Requests, register writes and the mode bit change only between clock edges. Register addresses are drawn both inside and outside the window.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int GRP_W  = 2;
  localparam int RANK_W = 4;
  localparam int KEY_W  = GRP_W + RANK_W;

  // reset rank: low bits of the channel index
  function automatic logic [RANK_W-1:0] rank_at_reset(input int n);
    return RANK_W'(n % (1 << RANK_W));
  endfunction

  // fixed group: next bits of the channel index
  function automatic logic [GRP_W-1:0] group_of(input int n);
    return GRP_W'((n >> RANK_W) % (1 << GRP_W));
  endfunction

  function automatic logic [KEY_W-1:0] make_key(input logic [GRP_W-1:0] g,
                                                input logic [RANK_W-1:0] r);
    return {g, r};
  endfunction

  function automatic logic [7:0] pack_reg(input logic allow,
                                          input logic [GRP_W-1:0] g,
                                          input logic [RANK_W-1:0] r);
    return {allow, 1'b0, g, r};
  endfunction
endpackage

// File: rtl/prio_regbank.sv
module prio_regbank
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH   = 32,
  parameter int ADDR_W   = 8,
  parameter int REG_BASE = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [7:0]                    wdata,
  output logic [7:0]                    rdata,
  output logic [NUM_CH-1:0]             allow_vec,
  output logic [NUM_CH-1:0][KEY_W-1:0]  key_vec
);
  localparam int CH_W = $clog2(NUM_CH);

  logic [ADDR_W-1:0]                offs;
  logic                             hit;
  logic [CH_W-1:0]                  idx;
  logic [NUM_CH-1:0][RANK_W-1:0]    rank_vec;
  logic [NUM_CH-1:0][GRP_W-1:0]     grp_vec;

  assign offs = addr - ADDR_W'(REG_BASE);
  assign hit  = offs < ADDR_W'(NUM_CH);
  assign idx  = offs[CH_W-1:0];

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic wr_sel;
    assign wr_sel = wr_en && hit && (idx == CH_W'(n));
    assign grp_vec[n] = group_of(n);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        allow_vec[n] <= 1'b0;
        rank_vec[n]  <= rank_at_reset(n);
      end else if (wr_sel) begin
        allow_vec[n] <= wdata[7];
        rank_vec[n]  <= wdata[RANK_W-1:0];
      end
    end

    assign key_vec[n] = make_key(grp_vec[n], rank_vec[n]);
  end

  always_comb begin
    rdata = 8'h00;
    if (hit) rdata = pack_reg(allow_vec[idx], grp_vec[idx], rank_vec[idx]);
  end

  // a write outside the window must leave every register alone
  p_stray_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hit) |=> ($stable(allow_vec) && $stable(rank_vec)));
endmodule

// File: rtl/prio_select.sv
module prio_select
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 32,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0]             req,
  input  logic [NUM_CH-1:0][KEY_W-1:0]  key_vec,
  input  logic                          fixed_en,
  output logic                          any,
  output logic [CH_W-1:0]               win_ch,
  output logic [KEY_W-1:0]              win_key
);
  // scan from the top index down; ">=" lets a lower index take a tie
  always_comb begin
    logic [KEY_W-1:0] k;
    any     = 1'b0;
    win_ch  = '0;
    win_key = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      k = fixed_en ? key_vec[i] : '0;
      if (req[i] && (!any || k >= win_key)) begin
        any     = 1'b1;
        win_ch  = CH_W'(i);
        win_key = k;
      end
    end
  end
endmodule

// File: rtl/grant_ctl.sv
module grant_ctl
  import dma_arb_pkg::*;
#(
  parameter int CH_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any,
  input  logic [CH_W-1:0]   win_ch,
  input  logic [KEY_W-1:0]  win_key,
  input  logic              busy,
  input  logic              fixed_en,
  input  logic [KEY_W-1:0]  act_key,
  input  logic              act_allow,
  output logic              fire,
  output logic              preempt,
  output logic              grant,
  output logic [CH_W-1:0]   grant_ch
);
  assign preempt = busy && fixed_en && act_allow && any && (win_key > act_key);
  assign fire    = any && (!busy || preempt) && !grant;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant    <= 1'b0;
      grant_ch <= '0;
    end else begin
      grant <= fire;
      if (fire) grant_ch <= win_ch;
    end
  end

  p_grant_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> !grant);
  p_ch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !grant |-> $stable(grant_ch));
endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH   = 32,
  parameter int ADDR_W   = 8,
  parameter int REG_BASE = 64,
  localparam int CH_W    = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              fixed_prio_en,
  input  logic [NUM_CH-1:0] req,
  input  logic              engine_busy,
  input  logic [CH_W-1:0]   active_ch,
  output logic              grant,
  output logic [CH_W-1:0]   grant_ch,
  output logic              preempt_req
);
  logic [NUM_CH-1:0]             allow_vec;
  logic [NUM_CH-1:0][KEY_W-1:0]  key_vec;
  logic                          any_req;
  logic [CH_W-1:0]               win_ch;
  logic [KEY_W-1:0]              win_key;
  logic                          grant_fire;

  prio_regbank #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .REG_BASE(REG_BASE)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .allow_vec(allow_vec), .key_vec(key_vec)
  );

  prio_select #(.NUM_CH(NUM_CH)) u_sel (
    .req(req), .key_vec(key_vec), .fixed_en(fixed_prio_en),
    .any(any_req), .win_ch(win_ch), .win_key(win_key)
  );

  grant_ctl #(.CH_W(CH_W)) u_gnt (
    .clk(clk), .rst_n(rst_n), .any(any_req), .win_ch(win_ch),
    .win_key(win_key), .busy(engine_busy), .fixed_en(fixed_prio_en),
    .act_key(key_vec[active_ch]), .act_allow(allow_vec[active_ch]),
    .fire(grant_fire), .preempt(preempt_req),
    .grant(grant), .grant_ch(grant_ch)
  );

  p_win_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |-> req[win_ch]);
  p_no_preempt_unranked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !fixed_prio_en |-> !preempt_req);
  p_preempt_needs_allow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    preempt_req |-> (engine_busy && allow_vec[active_ch]));
  p_busy_no_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (engine_busy && !preempt_req) |=> !grant);
  p_fire_on_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    grant_fire |-> (req != '0));
endmodule

// File: tb/dma_prio_arbiter_test.sv
`timescale 1ns/1ps
module dma_prio_arbiter_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_we = 0;
  logic [7:0]  reg_addr = 0;
  logic [7:0]  reg_wdata = 0;
  logic [7:0]  reg_rdata;
  logic        fixed_prio_en = 1;
  logic [31:0] req = 0;
  logic        engine_busy = 0;
  logic [4:0]  active_ch = 0;
  logic        grant;
  logic [4:0]  grant_ch;
  logic        preempt_req;

  always #10 clk = ~clk;

  dma_prio_arbiter uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fixed_prio_en(fixed_prio_en),
    .req(req), .engine_busy(engine_busy), .active_ch(active_ch),
    .grant(grant), .grant_ch(grant_ch), .preempt_req(preempt_req)
  );

  int tests = 0, fails = 0;
  bit done = 0;

  // reference state
  int allow_m[32], rank_m[32], grp_m[32];
  bit grant_m = 0;
  int ch_m = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int full_key(input int i);
    return grp_m[i] * 16 + rank_m[i];
  endfunction

  function automatic int model_read(input int a);
    int n = a - 64;
    if (n < 0 || n > 31) return 0;
    return allow_m[n] * 128 + grp_m[n] * 16 + rank_m[n];
  endfunction

  task automatic tick();
    int best = -1, bkey = -1;
    bit pm, fm;
    string tg, tc, tp;
    #1;
    for (int i = 0; i < 32; i++) begin
      int k = fixed_prio_en ? full_key(i) : 0;
      if (req[i] && k > bkey) begin best = i; bkey = k; end
    end
    pm = engine_busy && fixed_prio_en && allow_m[active_ch] == 1 && best >= 0
         && bkey > full_key(active_ch);
    tp = fixed_prio_en ? "R8" : "R5";
    chk(preempt_req === pm, tp, preempt_req, pm);
    chk(reg_rdata === 8'(model_read(reg_addr)), "R2", reg_rdata, model_read(reg_addr));
    fm = best >= 0 && (!engine_busy || pm) && !grant_m;
    tg = engine_busy ? "R9" : "R6";
    tc = fixed_prio_en ? "R4" : "R5";
    @(posedge clk);
    if (reg_we && reg_addr >= 64 && reg_addr < 96) begin
      allow_m[reg_addr - 64] = reg_wdata[7];
      rank_m[reg_addr - 64]  = reg_wdata[3:0];
    end
    grant_m = fm;
    if (fm) ch_m = best;
    @(negedge clk);
    chk(grant === grant_m, tg, grant, grant_m);
    chk(grant_ch === 5'(ch_m), fm ? tc : "R7", grant_ch, ch_m);
  endtask

  task automatic wr(input int a, input int d);
    reg_we = 1; reg_addr = 8'(a); reg_wdata = 8'(d);
    tick();
    reg_we = 0;
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    reg_addr = 8'(a);
    #1;
    chk(reg_rdata === 8'(exp), tag, reg_rdata, exp);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      allow_m[i] = 0; rank_m[i] = i % 16; grp_m[i] = i / 16;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(grant === 1'b0, "R6", grant, 0);
    chk(grant_ch === 5'd0, "R7", grant_ch, 0);
    chk(preempt_req === 1'b0, "R8", preempt_req, 0);
    for (int i = 0; i < 32; i++) rd(64 + i, (i / 16) * 16 + (i % 16), "R1");
    rd(95, 8'h1F, "R1");

    // R3: group and reserved bits ignore writes
    wr(95, 8'hFF);  rd(95, 8'h9F, "R3");
    wr(69, 8'h6A);  rd(69, 8'h0A, "R3");
    wr(69, 8'h05);  rd(69, 8'h05, "R3");
    // R2: stray write and read outside window
    wr(32, 8'hFF);  rd(64, 8'h00, "R2"); rd(32, 0, "R2"); rd(96, 0, "R2");
    reg_addr = 64;

    // R4: group dominates
    req = (32'd1 << 3) | (32'd1 << 20); tick(); tick();
    // R4: rank within group
    req = (32'd1 << 2) | (32'd1 << 9); tick(); tick();
    // R4: rank tie goes to lower index
    req = 0; wr(68, 8'h09);
    req = (32'd1 << 4) | (32'd1 << 9); tick(); tick();
    // R5: unranked mode
    fixed_prio_en = 0; req = (32'd1 << 9) | (32'd1 << 20); tick(); tick();
    engine_busy = 1; active_ch = 9; tick();
    fixed_prio_en = 1;
    // R8/R9: no preempt without allow
    req = 32'd1 << 20; active_ch = 2; tick(); tick();
    wr(66, 8'h82); tick(); tick();
    // R9: equal rank never preempts
    engine_busy = 1; active_ch = 4; wr(68, 8'h89);
    req = 32'd1 << 9; tick(); tick();
    engine_busy = 0; req = 0; tick();

    // mixed traffic with a simple engine
    begin
      int left = 0;
      for (int c = 0; c < 3000; c++) begin
        if (grant) begin
          engine_busy = 1; active_ch = grant_ch; left = $urandom_range(1, 6);
        end else if (engine_busy) begin
          left--;
          if (left == 0) begin engine_busy = 0; req[active_ch] = 1'b0; end
        end
        req = req | ($urandom & $urandom & $urandom);
        fixed_prio_en = ($urandom_range(0, 9) != 0);
        reg_we = ($urandom_range(0, 7) == 0);
        reg_addr = 8'($urandom_range(56, 100));
        reg_wdata = 8'($urandom);
        tick();
      end
      reg_we = 0;
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule